// File: doc/BRIEF.md
# Extended Interrupt Group Register Bank

This block holds the group assignment for the shared interrupts of the extended range. Each of up to 32 word-wide registers carries one bit per interrupt. A 0 places the interrupt in group 0, which is the secure group while security is active. A 1 places it in group 1, which is the non-secure group 1 while security is active. Software reaches the bank through a simple register port, and each access is tagged secure or non-secure. The stored bits drive a flat group vector that feeds the rest of the interrupt controller.

Every access is filtered bit by bit. A bit is hidden (reads as zero, ignores writes) if any of these holds:
- the extended range is switched off;
- its register lies above the configured range;
- its interrupt is not implemented;
- the routing enable of the security state that owns the interrupt is off;
- the access is non-secure and security is active, and the interrupt is secure.

While security is active, non-secure writes change nothing. This stops them from pulling an interrupt into the secure group. A small lookup port turns an interrupt ID into the register index and bit position that hold it.

Top module: `igrp_bank`

## Requirements
- R1: While `rst` is high, every register is cleared to zero on the next clock edge. In the cycle after reset, `group_vec`, `bus_rdata` and the lookup outputs are all zero.
- R2: A register is selected when `bus_addr` equals 0x1000 + 4*n for n = 0..31. The selected index is n. Any other address, whether misaligned or outside 0x1000..0x107C, returns zero and changes no register.
- R3: While `ext_en` is 0, every read returns zero and no write changes any register.
- R4: While `ext_en` is 1, the registers with index n <= `range_cfg` are live. The others read zero and ignore writes, and their stored contents are kept.
- R5: Bit b of register n stands for interrupt index 32*n+b. If that index is at or above `NUM_IRQ`, the bit reads zero and ignores writes.
- R6: The owning routing enable of a bit is chosen as follows. While `sec_off` is 1, it is `are_s`. While `sec_off` is 0, it is `are_s` for a stored 0 and `are_ns` for a stored 1. If that enable is 0, the bit reads zero and ignores writes.
- R7: While `sec_off` is 0, a non-secure access reads zero in every bit whose stored value is 0. Such an access never changes any register, so it can neither set nor clear a bit.
- R8: A secure access, or any access while `sec_off` is 1, reads every visible bit as stored. Its write sets or clears every visible bit to the written value.
- R9: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled. In every cycle that follows no read, `bus_rdata` is zero.
- R10: `group_vec[32*n+b]` equals bit b of register n. It changes on the same clock edge that samples the write.
- R11: For `loc_id` in 4096..5119, the cycle after it is sampled shows `loc_ok`=1, `loc_reg`=(id-4096)/32 and `loc_bit`=(id-4096) mod 32. For any other ID, all three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Extended interrupt range present |
| range_cfg | input | 5 | Highest live register index |
| sec_off | input | 1 | Security disabled (single security state) |
| are_s | input | 1 | Routing enable, secure state |
| are_ns | input | 1 | Routing enable, non-secure state |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_secure | input | 1 | Access is secure |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| group_vec | output | 1024 | Group bit per interrupt |
| loc_id | input | 13 | Interrupt ID to locate |
| loc_ok | output | 1 | ID lies in the extended range |
| loc_reg | output | 5 | Register index holding the ID |
| loc_bit | output | 5 | Bit position holding the ID |

## Verification
The assertions assume that the configuration inputs (`ext_en`, `range_cfg`, `sec_off`, `are_s`, `are_ns`) are steady at the clock edge that samples an access. They also assume that reset is held for at least one edge before any traffic. The stimulus changes configuration only on the falling edge and only between accesses, and it never raises `bus_rd` and `bus_wr` together. Because of this, each frozen-state property sees one well-defined access per cycle.

// File: rtl/igrp_pkg.sv
package igrp_pkg;

  // Security view of one access
  typedef struct packed {
    logic secure;
    logic sec_off;
    logic are_s;
    logic are_ns;
  } acc_ctx_t;

  // Routing enable of the state that owns an interrupt with stored group bit cur
  function automatic logic owner_routing(acc_ctx_t c, logic cur);
    if (c.sec_off) return c.are_s;
    return cur ? c.are_ns : c.are_s;
  endfunction

endpackage

// File: rtl/igrp_decode.sv
module igrp_decode #(
  parameter int ADDR_W = 16,
  parameter int NUM_REGS = 32,
  parameter logic [ADDR_W-1:0] BASE_OFS = 16'h1000,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_REGS);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] word;

  assign off  = addr - BASE_OFS;
  assign word = off >> 2;
  assign hit  = (addr >= BASE_OFS) && (off < SPAN) && (addr[1:0] == 2'b00);
  assign idx  = word[IDX_W-1:0];
endmodule

// File: rtl/igrp_bitmask.sv
module igrp_bitmask
  import igrp_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W = 32,
  parameter int NUM_IRQ = 1024,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] cur,
  input  logic [IDX_W-1:0] range_cfg,
  input  logic             ext_en,
  input  acc_ctx_t         ctx,
  output logic [REG_W-1:0] vis,
  output logic [REG_W-1:0] wmask
);
  logic reg_live;
  logic acc_full;

  assign reg_live = ext_en && (idx <= range_cfg);
  assign acc_full = ctx.sec_off || ctx.secure;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    logic impl;
    assign impl     = ((int'(idx) * REG_W + b) < NUM_IRQ);
    assign vis[b]   = reg_live && impl && owner_routing(ctx, cur[b]) && (acc_full || cur[b]);
    assign wmask[b] = vis[b] && acc_full;
  end
endmodule

// File: rtl/igrp_locate.sv
module igrp_locate #(
  parameter int ID_W = 13,
  parameter int BASE_ID = 4096,
  parameter int NUM_REGS = 32,
  parameter int REG_W = 32,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int BIT_W = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  id,
  output logic             ok,
  output logic [IDX_W-1:0] reg_idx,
  output logic [BIT_W-1:0] bit_idx
);
  localparam logic [ID_W-1:0] BASE = ID_W'(BASE_ID);
  localparam logic [ID_W-1:0] SPAN = ID_W'(NUM_REGS * REG_W);

  logic [ID_W-1:0] rel;
  logic            in_rng;

  assign rel    = id - BASE;
  assign in_rng = (id >= BASE) && (rel < SPAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ok      <= 1'b0;
      reg_idx <= '0;
      bit_idx <= '0;
    end else begin
      ok      <= in_rng;
      reg_idx <= in_rng ? rel[BIT_W +: IDX_W] : '0;
      bit_idx <= in_rng ? rel[BIT_W-1:0] : '0;
    end
  end

  // R11: IDs below the extended base never locate
  p_low_id_r11: assert property (@(posedge clk) disable iff (rst)
    (id < BASE) |=> !ok);
  // R11: IDs past the last implemented slot never locate
  p_high_id_r11: assert property (@(posedge clk) disable iff (rst)
    (id >= BASE && rel >= SPAN) |=> (!ok && reg_idx == '0));
endmodule

// File: rtl/igrp_bank.sv
module igrp_bank
  import igrp_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W = 32,
  parameter int NUM_IRQ = 1024,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_OFS = 16'h1000,
  parameter int ID_W = 13,
  parameter int BASE_ID = 4096,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int BIT_W = $clog2(REG_W),
  localparam int VEC_W = NUM_REGS * REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_en,
  input  logic [IDX_W-1:0]  range_cfg,
  input  logic              sec_off,
  input  logic              are_s,
  input  logic              are_ns,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_secure,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [VEC_W-1:0]  group_vec,
  input  logic [ID_W-1:0]   loc_id,
  output logic              loc_ok,
  output logic [IDX_W-1:0]  loc_reg,
  output logic [BIT_W-1:0]  loc_bit
);
  logic [REG_W-1:0] bank [NUM_REGS];
  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic [REG_W-1:0] cur_word;
  logic [REG_W-1:0] vis;
  logic [REG_W-1:0] wmask;
  acc_ctx_t         ctx;

  assign ctx = '{secure: bus_secure, sec_off: sec_off, are_s: are_s, are_ns: are_ns};

  igrp_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BASE_OFS(BASE_OFS)
  ) i_decode (
    .addr(bus_addr), .hit(dec_hit), .idx(dec_idx)
  );

  assign cur_word = bank[dec_idx];

  igrp_bitmask #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .NUM_IRQ(NUM_IRQ)
  ) i_mask (
    .idx(dec_idx), .cur(cur_word), .range_cfg(range_cfg), .ext_en(ext_en),
    .ctx(ctx), .vis(vis), .wmask(wmask)
  );

  // Storage and write merge
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (bus_wr && dec_hit) begin
      bank[dec_idx] <= (cur_word & ~wmask) | (bus_wdata & wmask);
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= (bus_rd && dec_hit) ? (cur_word & vis) : '0;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_vec
    assign group_vec[r*REG_W +: REG_W] = bank[r];
  end

  igrp_locate #(
    .ID_W(ID_W), .BASE_ID(BASE_ID), .NUM_REGS(NUM_REGS), .REG_W(REG_W)
  ) i_locate (
    .clk(clk), .rst(rst), .id(loc_id),
    .ok(loc_ok), .reg_idx(loc_reg), .bit_idx(loc_bit)
  );

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (group_vec == '0 && bus_rdata == '0));
  // R9
  p_idle_rdata_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
  // R2
  p_miss_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !dec_hit) |=> $stable(group_vec));
  p_miss_no_read_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !dec_hit) |=> bus_rdata == '0);
  // R3
  p_off_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !ext_en) |=> $stable(group_vec));
  p_off_no_read_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !ext_en) |=> bus_rdata == '0);
  // R4
  p_above_range_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec_hit && dec_idx > range_cfg) |=> $stable(group_vec));
  // R7
  p_ns_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_secure && !sec_off) |=> $stable(group_vec));
endmodule

// File: tb/test_igrp_bank.sv
module test_igrp_bank;
  localparam int NIRQ = 1000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ext_en = 1'b0;
  logic [4:0]   range_cfg = '0;
  logic         sec_off = 1'b1;
  logic         are_s = 1'b1;
  logic         are_ns = 1'b1;
  logic         bus_rd = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_secure = 1'b1;
  logic [15:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [1023:0] group_vec;
  logic [12:0]  loc_id = '0;
  logic         loc_ok;
  logic [4:0]   loc_reg;
  logic [4:0]   loc_bit;

  always #10 clk = ~clk;

  igrp_bank #(.NUM_IRQ(NIRQ)) i_igrp_bank (
    .clk(clk), .rst(rst), .ext_en(ext_en), .range_cfg(range_cfg),
    .sec_off(sec_off), .are_s(are_s), .are_ns(are_ns),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_secure(bus_secure),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .group_vec(group_vec), .loc_id(loc_id), .loc_ok(loc_ok),
    .loc_reg(loc_reg), .loc_bit(loc_bit)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  int    cycles = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Reference model state
  logic [31:0]   m_bank [32];
  logic [31:0]   exp_rd;
  logic [1023:0] exp_vec;
  logic          exp_ok;
  logic [4:0]    exp_reg, exp_bit;
  bit            m_hit;
  int            m_r;
  logic [31:0]   m_new;

  function automatic bit m_vis(int r, int b, bit cur, bit sec);
    bit owner;
    if (!ext_en) return 0;
    if (r > int'(range_cfg)) return 0;
    if (r * 32 + b >= NIRQ) return 0;
    owner = sec_off ? are_s : (cur ? are_ns : are_s);
    if (!owner) return 0;
    if (!sec_off && !sec && !cur) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      for (int r = 0; r < 32; r++) m_bank[r] = '0;
      exp_rd = '0; exp_ok = 0; exp_reg = '0; exp_bit = '0;
    end else begin
      m_hit = (bus_addr[1:0] == 2'b00) && (bus_addr >= 16'h1000) && (bus_addr <= 16'h107C);
      m_r = (int'(bus_addr) - 4096) / 4;
      exp_rd = '0;
      if (bus_rd && m_hit)
        for (int b = 0; b < 32; b++)
          if (m_vis(m_r, b, m_bank[m_r][b], bus_secure)) exp_rd[b] = m_bank[m_r][b];
      if (bus_wr && m_hit) begin
        m_new = m_bank[m_r];
        for (int b = 0; b < 32; b++)
          if (m_vis(m_r, b, m_bank[m_r][b], bus_secure) && (sec_off || bus_secure))
            m_new[b] = bus_wdata[b];
        m_bank[m_r] = m_new;
      end
      if (loc_id >= 13'd4096 && loc_id < 13'd5120) begin
        exp_ok = 1;
        exp_reg = 5'((int'(loc_id) - 4096) / 32);
        exp_bit = 5'((int'(loc_id) - 4096) % 32);
      end else begin
        exp_ok = 0; exp_reg = '0; exp_bit = '0;
      end
    end
    for (int r = 0; r < 32; r++) exp_vec[r*32 +: 32] = m_bank[r];
  end

  // Compare every cycle on the falling edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_vec++;
      if (bus_rdata !== exp_rd) begin
        n_bad++;
        $display("FAIL %s rdata act=%h exp=%h t=%0t", cur_req, bus_rdata, exp_rd, $time);
      end
      n_vec++;
      if (group_vec !== exp_vec) begin
        n_bad++;
        $display("FAIL R10 %s group_vec act=%h exp=%h", cur_req, group_vec, exp_vec);
      end
      n_vec++;
      if ({loc_ok, loc_reg, loc_bit} !== {exp_ok, exp_reg, exp_bit}) begin
        n_bad++;
        $display("FAIL R11 lookup act=%b/%0d/%0d exp=%b/%0d/%0d",
                 loc_ok, loc_reg, loc_bit, exp_ok, exp_reg, exp_bit);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d cycles exp=done", cycles);
      finish_run();
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input bit sec);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d; bus_secure = sec;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, input bit sec);
    @(negedge clk);
    bus_rd = 1; bus_wr = 0; bus_addr = a; bus_secure = sec;
    @(negedge clk);
    bus_rd = 0;
  endtask

  function automatic logic [15:0] ra(int n);
    return 16'(4096 + 4 * n);
  endfunction

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    ext_en = 1; range_cfg = 5'd31; sec_off = 1; are_s = 1; are_ns = 1;
    rd(ra(0), 1);

    cur_req = "R8";
    wr(ra(0), 32'hDEAD_BEEF, 0);
    rd(ra(0), 0);
    wr(ra(7), 32'h1234_5678, 1);
    wr(ra(7), 32'h0000_00F0, 1);
    rd(ra(7), 1);

    cur_req = "R9";
    repeat (2) @(negedge clk);

    cur_req = "R2";
    wr(16'h1001, 32'hFFFF_FFFF, 1);
    wr(16'h0FFC, 32'hFFFF_FFFF, 1);
    wr(16'h1080, 32'hFFFF_FFFF, 1);
    rd(16'h1002, 1);
    rd(16'h2000, 1);
    rd(ra(31), 1);

    cur_req = "R4";
    wr(ra(5), 32'hA5A5_A5A5, 1);
    range_cfg = 5'd3;
    rd(ra(5), 1);
    wr(ra(5), 32'h0, 1);
    rd(ra(3), 1);
    range_cfg = 5'd31;
    rd(ra(5), 1);

    cur_req = "R3";
    ext_en = 0;
    rd(ra(0), 1);
    wr(ra(1), 32'hFFFF_FFFF, 1);
    ext_en = 1;
    rd(ra(1), 1);

    cur_req = "R5";
    wr(ra(31), 32'hFFFF_FFFF, 1);
    rd(ra(31), 1);

    cur_req = "R7";
    sec_off = 0;
    wr(ra(2), 32'h0000_FF00, 1);
    rd(ra(2), 0);
    wr(ra(2), 32'h0000_0000, 0);
    wr(ra(2), 32'hFFFF_FFFF, 0);
    rd(ra(2), 1);

    cur_req = "R6";
    are_ns = 0;
    rd(ra(2), 1);
    wr(ra(2), 32'h0000_000F, 1);
    are_ns = 1; are_s = 0;
    rd(ra(2), 1);
    wr(ra(2), 32'hFFFF_FFFF, 1);
    wr(ra(2), 32'h0000_0000, 1);
    are_s = 1;
    rd(ra(2), 1);
    sec_off = 1; are_s = 0;
    rd(ra(0), 1);
    are_s = 1;

    cur_req = "R11";
    foreach (loc_id_list[i]) begin
      @(negedge clk);
      loc_id = loc_id_list[i];
    end
    @(negedge clk);

    cur_req = "R10";
    for (int k = 0; k < 800; k++) begin
      if (k % 40 == 0) begin
        @(negedge clk);
        ext_en = ($urandom % 8) != 0;
        range_cfg = 5'($urandom);
        sec_off = $urandom % 2;
        are_s = ($urandom % 4) != 0;
        are_ns = ($urandom % 4) != 0;
      end
      loc_id = 13'(4000 + $urandom % 1200);
      if ($urandom % 2)
        wr((($urandom % 10) == 0) ? 16'($urandom) : ra($urandom % 32), $urandom, $urandom % 2);
      else
        rd((($urandom % 10) == 0) ? 16'($urandom) : ra($urandom % 32), $urandom % 2);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end

  logic [12:0] loc_id_list [8] = '{13'd0, 13'd4095, 13'd4096, 13'd4127,
                                   13'd4128, 13'd5119, 13'd5120, 13'd8191};
endmodule